// File: doc/BRIEF.md
# Packed SIMD Saturating ALU

This block is a single-cycle arithmetic unit for 64-bit packed integer data. Each operation treats the 64-bit word either as eight unsigned 8-bit lanes or as four signed 16-bit lanes, and applies the same lane operation to every lane at once. The lane operations are bitwise logic, shifts, saturating add/subtract/multiply, minimum and maximum, a sign-transfer operation for signed lanes, and absolute difference and rounded average for unsigned lanes.

The first operand is always a full vector. The second operand is built from a 5-bit format/select field. It can be the whole second vector. It can be one lane of that vector copied into every lane. It can be a small unsigned immediate copied into every lane. The result and an illegal-operation flag are registered and appear one clock after the inputs. An opcode that the selected lane format does not define gives an all-zero result and sets the flag for that result's cycle.

Top module: `simd_sat_alu`

## Requirements
- R1: While `rst` is high at a rising clock edge, `result` becomes 0 and `illegal_op` becomes 0 at that edge, whatever the other inputs are.
- R2: `fmt_sel` bit 0 picks the lane format: 0 gives eight unsigned byte lanes (lane i at bits 8i+7..8i), and 1 gives four signed halfword lanes (lane i at bits 16i+15..16i). The result for the inputs present at a rising edge appears on the outputs after that edge.
- R3: `fmt_sel` bits 4:3 choose the second operand. With bit 4 at 0, one lane of `opnd_b` goes to all lanes; that lane's index is bits 3:1 for bytes and bits 3:2 for halfwords. The value 2'b10 selects all of `opnd_b`. The value 2'b11 selects `imm`, zero-extended to lane width, in all lanes.
- R4: Opcodes 0, 1, 2 and 3 give the lane-wise AND, NOR, OR and XOR.
- R5: Opcode 4 shifts left logically and opcode 5 shifts right logically. Opcode 12 shifts right arithmetically and exists for halfwords only. The shift amount is the low 3 bits (bytes) or low 4 bits (halfwords) of the operand-2 lane.
- R6: Opcodes 6 (add), 7 (subtract) and 10 (multiply) saturate. Byte results clamp to 0..255, so subtraction is floored at 0. Halfword results clamp to -32768..32767.
- R7: Opcode 8 gives the lane minimum and opcode 9 the lane maximum. Bytes compare unsigned and halfwords compare signed.
- R8: Opcode 11, for halfwords only, is sign transfer. It gives 0 when the operand-1 lane is 0, and the operand-2 lane when operand 1 is positive. When operand 1 is negative it gives the negated operand-2 lane, with -32768 giving 32767.
- R9: Opcode 13 (absolute difference |a-b|) and opcode 14 (rounded average (a+b+1)>>1) exist for byte lanes only.
- R10: Some opcodes are undefined for the selected format: 11 and 12 for bytes, 13 and 14 for halfwords, and 15 for both. For these, the registered result is all zero and `illegal_op` is 1. `illegal_op` is 0 for the next defined operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opnd_a | input | 64 | First operand vector |
| opnd_b | input | 64 | Second operand vector, or the source of the broadcast lane |
| imm | input | 8 | Unsigned immediate for immediate-broadcast mode |
| fmt_sel | input | 5 | Lane format (bit 0), operand-2 mode (bits 4:3), element index (bits 3:1 or 3:2) |
| opcode | input | 4 | Lane operation code |
| result | output | 64 | Registered packed result |
| illegal_op | output | 1 | Registered flag for an opcode undefined in the selected format |

## Verification
Byte lanes are swept over every first-operand value against a dense stride of second-operand values, for all sixteen opcodes. Each of the eight lanes carries a different pair, so a lane-slice or carry mistake shows up in one lane only. Halfword lanes are swept over every pair drawn from a set of boundary values: 0, ±1, ±2, the extremes and their neighbours, and shift-width edges. These pairs separate saturation direction, signed versus unsigned comparison, the sign-transfer special case and arithmetic versus logical shifting. Element-broadcast mode is run with every lane index and immediate mode with edge immediates on pseudo-random vectors. Together these tell index decoding, the unused field bit and immediate zero-extension apart from the plain vector path.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,
    OP_NOR = 4'd1,
    OP_OR  = 4'd2,
    OP_XOR = 4'd3,
    OP_SLL = 4'd4,
    OP_SRL = 4'd5,
    OP_ADD = 4'd6,
    OP_SUB = 4'd7,
    OP_MIN = 4'd8,
    OP_MAX = 4'd9,
    OP_MUL = 4'd10,
    OP_SGN = 4'd11,
    OP_SRA = 4'd12,
    OP_ADF = 4'd13,
    OP_AVG = 4'd14,
    OP_RSV = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    SRC_ELEM = 2'd0,
    SRC_VEC  = 2'd1,
    SRC_IMM  = 2'd2
  } src_mode_e;

  // Operand-2 mode from the two top bits of the select field.
  function automatic src_mode_e decode_src(input logic [1:0] mode_bits);
    if (!mode_bits[1])     return SRC_ELEM;
    else if (!mode_bits[0]) return SRC_VEC;
    else                    return SRC_IMM;
  endfunction

  function automatic logic byte_op_undefined(input alu_op_e op);
    return (op == OP_SGN) || (op == OP_SRA) || (op == OP_RSV);
  endfunction

  function automatic logic half_op_undefined(input alu_op_e op);
    return (op == OP_ADF) || (op == OP_AVG) || (op == OP_RSV);
  endfunction

endpackage

// File: rtl/simd_opnd_sel.sv
module simd_opnd_sel
  import simd_alu_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int LANE_W  = 8,
  parameter int IMM_W   = 8,
  parameter int IDX_LSB = 1
) (
  input  logic [DATA_W-1:0]  vec_b,
  input  logic [IMM_W-1:0]   imm,
  input  logic [4-IDX_LSB:0] sel_hi,
  output logic [DATA_W-1:0]  opnd
);
  localparam int NL    = DATA_W / LANE_W;
  localparam int IDX_W = $clog2(NL);
  localparam int SEL_W = 5 - IDX_LSB;

  src_mode_e         mode;
  logic [IDX_W-1:0]  idx;
  logic [LANE_W-1:0] elem;
  logic [LANE_W-1:0] imm_ext;

  assign mode    = decode_src(sel_hi[SEL_W-1 -: 2]);
  assign idx     = sel_hi[IDX_W-1:0];
  assign imm_ext = LANE_W'(imm);

  always_comb begin
    elem = '0;
    for (int l = 0; l < NL; l++) begin
      if (idx == IDX_W'(l)) elem = vec_b[l*LANE_W +: LANE_W];
    end
  end

  for (genvar l = 0; l < NL; l++) begin : g_lane
    always_comb begin
      unique case (mode)
        SRC_VEC: opnd[l*LANE_W +: LANE_W] = vec_b[l*LANE_W +: LANE_W];
        SRC_IMM: opnd[l*LANE_W +: LANE_W] = imm_ext;
        default: opnd[l*LANE_W +: LANE_W] = elem;
      endcase
    end
  end

  // R3: every broadcast mode gives the same value in every lane
  always_comb begin
    if (mode != SRC_VEC) begin
      p_bcast_uniform_r3: assert ({NL{opnd[LANE_W-1:0]}} == opnd);
    end
  end

endmodule

// File: rtl/simd_byte_lane.sv
module simd_byte_lane
  import simd_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   res
);
  localparam int SH_W = $clog2(W);
  localparam logic [W-1:0] ONES = '1;

  logic [W:0]      sum;
  logic [W:0]      sum_rnd;
  logic [2*W-1:0]  prod;
  logic            a_ge_b;
  logic [W-1:0]    diff_ab;
  logic [W-1:0]    diff_ba;
  logic [SH_W-1:0] sh;

  assign sum     = {1'b0, a} + {1'b0, b};
  assign sum_rnd = sum + (W+1)'(1);
  assign prod    = {{W{1'b0}}, a} * {{W{1'b0}}, b};
  assign a_ge_b  = (a >= b);
  assign diff_ab = a - b;
  assign diff_ba = b - a;
  assign sh      = b[SH_W-1:0];

  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_NOR:  res = ~(a | b);
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_SLL:  res = a << sh;
      OP_SRL:  res = a >> sh;
      OP_ADD:  res = sum[W] ? ONES : sum[W-1:0];
      OP_SUB:  res = a_ge_b ? diff_ab : '0;
      OP_MIN:  res = a_ge_b ? b : a;
      OP_MAX:  res = a_ge_b ? a : b;
      OP_MUL:  res = (|prod[2*W-1:W]) ? ONES : prod[W-1:0];
      OP_ADF:  res = a_ge_b ? diff_ab : diff_ba;
      OP_AVG:  res = sum_rnd[W:1];
      default: res = '0;
    endcase
  end

  always_comb begin
    if (op == OP_ADD) begin
      p_add_not_below_r6: assert (res >= a && res >= b);
    end
    if (op == OP_SUB) begin
      p_sub_not_above_r6: assert (res <= a);
    end
    if (op == OP_AVG) begin
      p_avg_between_r9: assert ((res >= a || res >= b) && (res <= a || res <= b));
    end
  end

endmodule

// File: rtl/simd_half_lane.sv
module simd_half_lane
  import simd_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   res
);
  localparam int SH_W = $clog2(W);
  localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};

  logic [W:0]            sum;
  logic [W:0]            dif;
  logic signed [2*W-1:0] prod;
  logic                  prod_ovf;
  logic                  a_lt_b;
  logic [W-1:0]          neg_b;
  logic [SH_W-1:0]       sh;
  logic [W-1:0]          sra_v;

  assign sum      = {a[W-1], a} + {b[W-1], b};
  assign dif      = {a[W-1], a} - {b[W-1], b};
  assign prod     = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
  assign prod_ovf = !((&prod[2*W-1:W-1]) || !(|prod[2*W-1:W-1]));
  assign a_lt_b   = $signed(a) < $signed(b);
  assign neg_b    = W'(0) - b;
  assign sh       = b[SH_W-1:0];
  assign sra_v    = W'($signed(a) >>> sh);

  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_NOR:  res = ~(a | b);
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_SLL:  res = a << sh;
      OP_SRL:  res = a >> sh;
      OP_SRA:  res = sra_v;
      OP_ADD:  res = (sum[W] ^ sum[W-1]) ? (sum[W] ? S_MIN : S_MAX) : sum[W-1:0];
      OP_SUB:  res = (dif[W] ^ dif[W-1]) ? (dif[W] ? S_MIN : S_MAX) : dif[W-1:0];
      OP_MIN:  res = a_lt_b ? a : b;
      OP_MAX:  res = a_lt_b ? b : a;
      OP_MUL:  res = prod_ovf ? (prod[2*W-1] ? S_MIN : S_MAX) : prod[W-1:0];
      OP_SGN: begin
        if (a == '0)      res = '0;
        else if (a[W-1])  res = (b == S_MIN) ? S_MAX : neg_b;
        else              res = b;
      end
      default: res = '0;
    endcase
  end

  always_comb begin
    if (op == OP_SGN && a == '0) begin
      p_sgn_zero_r8: assert (res == '0);
    end
    if (op == OP_ADD && a[W-1] != b[W-1]) begin
      p_add_mixed_no_clamp_r6: assert (res == a + b);
    end
  end

endmodule

// File: rtl/simd_sat_alu.sv
module simd_sat_alu
  import simd_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic [4:0]        fmt_sel,
  input  logic [3:0]        opcode,
  output logic [DATA_W-1:0] result,
  output logic              illegal_op
);
  localparam int NB = DATA_W / BYTE_W;
  localparam int NH = DATA_W / HALF_W;

  alu_op_e           op;
  logic              is_half;
  logic [DATA_W-1:0] byte_b;
  logic [DATA_W-1:0] half_b;
  logic [DATA_W-1:0] byte_res;
  logic [DATA_W-1:0] half_res;
  logic              undef_c;
  logic [DATA_W-1:0] next_res;

  assign op      = alu_op_e'(opcode);
  assign is_half = fmt_sel[0];

  simd_opnd_sel #(
    .DATA_W(DATA_W), .LANE_W(BYTE_W), .IMM_W(IMM_W), .IDX_LSB(1)
  ) u_bsel (
    .vec_b(opnd_b), .imm(imm), .sel_hi(fmt_sel[4:1]), .opnd(byte_b)
  );

  simd_opnd_sel #(
    .DATA_W(DATA_W), .LANE_W(HALF_W), .IMM_W(IMM_W), .IDX_LSB(2)
  ) u_hsel (
    .vec_b(opnd_b), .imm(imm), .sel_hi(fmt_sel[4:2]), .opnd(half_b)
  );

  for (genvar i = 0; i < NB; i++) begin : g_byte
    simd_byte_lane #(.W(BYTE_W)) u_lane (
      .op (op),
      .a  (opnd_a[i*BYTE_W +: BYTE_W]),
      .b  (byte_b[i*BYTE_W +: BYTE_W]),
      .res(byte_res[i*BYTE_W +: BYTE_W])
    );
  end

  for (genvar i = 0; i < NH; i++) begin : g_half
    simd_half_lane #(.W(HALF_W)) u_lane (
      .op (op),
      .a  (opnd_a[i*HALF_W +: HALF_W]),
      .b  (half_b[i*HALF_W +: HALF_W]),
      .res(half_res[i*HALF_W +: HALF_W])
    );
  end

  assign undef_c  = is_half ? half_op_undefined(op) : byte_op_undefined(op);
  assign next_res = undef_c ? '0 : (is_half ? half_res : byte_res);

  always_ff @(posedge clk) begin
    if (rst) begin
      result     <= '0;
      illegal_op <= 1'b0;
    end else begin
      result     <= next_res;
      illegal_op <= undef_c;
    end
  end

  // R10: a flagged operation never carries data
  p_illegal_zero_r10: assert property (@(posedge clk) disable iff (rst)
    illegal_op |-> (result == '0));

  // R10: the reserved code is flagged in both formats on the next cycle
  p_reserved_flag_r10: assert property (@(posedge clk) disable iff (rst)
    (opcode == 4'd15) |=> illegal_op);

  // R10: a defined byte operation never raises the flag
  p_byte_legal_r10: assert property (@(posedge clk) disable iff (rst)
    (!fmt_sel[0] && opcode <= 4'd10) |=> !illegal_op);

  // R4: full-vector XOR lands unchanged one cycle later
  p_xor_vec_r4: assert property (@(posedge clk) disable iff (rst)
    (opcode == 4'd3 && fmt_sel[4:3] == 2'b10) |=> (result == $past(opnd_a ^ opnd_b)));

endmodule

// File: tb/simd_sat_alu_tb_top.sv
module simd_sat_alu_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] opnd_a = '0;
  logic [63:0] opnd_b = '0;
  logic [7:0]  imm = '0;
  logic [4:0]  fmt_sel = '0;
  logic [3:0]  opcode = 4'd15;
  logic [63:0] result;
  logic        illegal_op;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  simd_sat_alu dut_i (
    .clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm),
    .fmt_sel(fmt_sel), .opcode(opcode), .result(result), .illegal_op(illegal_op)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG_CYCLES && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below %0d", cycles, WATCHDOG_CYCLES);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [63:0] next_rand(input logic [63:0] s);
    logic [63:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  function automatic int clamp_s16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int byte_ref(input int x, input int y, input int op);
    case (op)
      0: return x & y;
      1: return (~(x | y)) & 255;
      2: return x | y;
      3: return x ^ y;
      4: return (x << (y % 8)) & 255;
      5: return x >> (y % 8);
      6: return (x + y > 255) ? 255 : x + y;
      7: return (x > y) ? x - y : 0;
      8: return (x < y) ? x : y;
      9: return (x > y) ? x : y;
      10: return (x * y > 255) ? 255 : x * y;
      13: return (x > y) ? x - y : y - x;
      14: return (x + y + 1) / 2;
      default: return 0;
    endcase
  endfunction

  function automatic int half_ref(input int x, input int y, input int op);
    case (op)
      0: return x & y;
      1: return ~(x | y);
      2: return x | y;
      3: return x ^ y;
      4: return x << (y & 15);
      5: return (x & 65535) >> (y & 15);
      6: return clamp_s16(x + y);
      7: return clamp_s16(x - y);
      8: return (x < y) ? x : y;
      9: return (x > y) ? x : y;
      10: return clamp_s16(x * y);
      11: begin
        if (x == 0) return 0;
        if (x > 0) return y;
        return (y == -32768) ? 32767 : -y;
      end
      12: return x >>> (y & 15);
      default: return 0;
    endcase
  endfunction

  function automatic bit undefined_op(input bit hw, input int op);
    if (op == 15) return 1;
    if (hw) return (op == 13 || op == 14);
    return (op == 11 || op == 12);
  endfunction

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic [7:0] im, input logic [4:0] sel,
                                        input int op);
    logic [63:0] r = '0;
    bit hw = sel[0];
    int mode = !sel[4] ? 0 : (sel[3] ? 2 : 1);
    if (undefined_op(hw, op)) return '0;
    if (!hw) begin
      int idx = int'(sel[3:1]);
      for (int k = 0; k < 8; k++) begin
        int x = int'(a[8*k +: 8]);
        int y = (mode == 1) ? int'(b[8*k +: 8]) : (mode == 2) ? int'(im) : int'(b[8*idx +: 8]);
        logic [31:0] t = byte_ref(x, y, op);
        r[8*k +: 8] = t[7:0];
      end
    end else begin
      int idx = int'(sel[3:2]);
      for (int k = 0; k < 4; k++) begin
        int x = $signed(a[16*k +: 16]);
        int y = (mode == 1) ? $signed(b[16*k +: 16]) :
                (mode == 2) ? int'(im) : $signed(b[16*idx +: 16]);
        logic [31:0] t = half_ref(x, y, op);
        r[16*k +: 16] = t[15:0];
      end
    end
    return r;
  endfunction

  function automatic string op_tag(input bit hw, input int op);
    if (undefined_op(hw, op)) return "R10";
    case (op)
      0, 1, 2, 3: return "R4";
      4, 5, 12: return "R5";
      6, 7, 10: return "R6";
      8, 9: return "R7";
      11: return "R8";
      default: return "R9";
    endcase
  endfunction

  // Inputs are applied at a falling edge, captured at the next rising edge,
  // and the registered outputs are compared at the falling edge after it.
  task automatic run(input logic [63:0] a, input logic [63:0] b, input logic [7:0] im,
                     input logic [4:0] sel, input int op, input string tg);
    logic [63:0] exp = model(a, b, im, sel, op);
    bit exp_ill = undefined_op(sel[0], op);
    string t = (tg == "") ? op_tag(sel[0], op) : tg;
    opnd_a = a;
    opnd_b = b;
    imm = im;
    fmt_sel = sel;
    opcode = 4'(op);
    @(negedge clk);
    checks++;
    if (result !== exp || illegal_op !== exp_ill) begin
      errors++;
      $display("FAIL %s op=%0d sel=%b: actual result=%h illegal=%b expected result=%h illegal=%b",
               t, op, sel, result, illegal_op, exp, exp_ill);
    end
  endtask

  int hvals[16] = '{0, 1, 2, -1, -2, 32767, 32766, -32768, -32767,
                    100, -100, 255, 256, 15, 16, 16384};

  initial begin
    // R1: outputs held at zero under reset even with an undefined opcode applied
    opnd_a = 64'hFFFF_FFFF_FFFF_FFFF;
    opnd_b = 64'h1234_5678_9ABC_DEF0;
    fmt_sel = 5'b10000;
    opcode = 4'd15;
    repeat (3) @(negedge clk);
    checks++;
    if (result !== 64'h0 || illegal_op !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual result=%h illegal=%b expected result=0 illegal=0",
               result, illegal_op);
    end
    rst = 1'b0;

    // R2: same operands, both formats, saturating add tells lane width and signedness apart
    run(64'h7FFF_8000_00FF_0080, 64'h0001_FFFF_0001_0080, 8'h00, 5'b10000, 6, "R2");
    run(64'h7FFF_8000_00FF_0080, 64'h0001_FFFF_0001_0080, 8'h00, 5'b10001, 6, "R2");

    // R10: flag for one cycle only, then clear on a defined operation
    run(64'h1, 64'h2, 8'h0, 5'b10000, 13, "R10");
    run(64'h1, 64'h2, 8'h0, 5'b10001, 13, "R10");
    run(64'h1, 64'h2, 8'h0, 5'b10001, 6, "R10");

    // Byte lanes: every first-operand value against a dense stride of second values
    for (int ab = 0; ab < 256; ab += 8) begin
      for (int bj = 0; bj < 256; bj += 9) begin
        logic [63:0] a = '0;
        logic [63:0] b = '0;
        for (int k = 0; k < 8; k++) begin
          a[8*k +: 8] = 8'(ab + k);
          b[8*k +: 8] = 8'(bj + 37 * k);
        end
        for (int op = 0; op < 16; op++) run(a, b, 8'h0, 5'b10000, op, "");
      end
    end

    // Halfword lanes: all pairs from a set of boundary values
    for (int ii = 0; ii < 16; ii++) begin
      for (int jj = 0; jj < 16; jj++) begin
        logic [63:0] a = '0;
        logic [63:0] b = '0;
        for (int k = 0; k < 4; k++) begin
          logic [31:0] xa = hvals[(ii + k) % 16];
          logic [31:0] xb = hvals[(jj + 3 * k) % 16];
          a[16*k +: 16] = xa[15:0];
          b[16*k +: 16] = xb[15:0];
        end
        for (int op = 0; op < 16; op++) run(a, b, 8'h0, 5'b10001, op, "");
      end
    end

    // R3: element broadcast with every index, and immediate broadcast with edge immediates
    for (int rep = 0; rep < 6; rep++) begin
      logic [63:0] a;
      logic [63:0] b;
      rng = next_rand(rng);
      a = rng;
      rng = next_rand(rng);
      b = rng;
      for (int op = 0; op < 16; op++) begin
        for (int idx = 0; idx < 8; idx++)
          run(a, b, 8'h5A, {1'b0, 3'(idx), 1'b0}, op, "R3");
        for (int idx = 0; idx < 4; idx++)
          run(a, b, 8'h5A, {1'b0, 2'(idx), 1'(rep % 2), 1'b1}, op, "R3");
        for (int s = 0; s < 4; s++) begin
          logic [7:0] im = (s == 0) ? 8'h00 : (s == 1) ? 8'h07 : (s == 2) ? 8'h80 : 8'hFF;
          run(a, b, im, {2'b11, 2'(rep), 1'b0}, op, "R3");
          run(a, b, im, {2'b11, 2'(rep), 1'b1}, op, "R3");
        end
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule